// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block turns one command write into a full program or erase run against an on-chip flash-array model. Software presents an operation code, a word address, a 16-bit data value and a pulse length in a single cycle. The sequencer then carries the operation through to the end with no further help.

A program operation applies timed pulses to one 16-bit word and reads the word back after each pulse. It retries until the read-back matches or the pulse budget is spent. An erase operation drives every word of one block back to all-ones. Each outcome ends in a one-cycle `done` pulse and a set of error flags.

Access is guarded at two levels:
- A seven-byte key, written one byte at a time, must be matched before reads, commands or lock changes are honoured.
- A lock bit per block refuses program and erase commands aimed at that block. At reset only the boot block is locked.

The array model clears at most one bit per program pulse. Because of this, the number of pulses a word needs is known in advance, and a word needing too many pulses shows the timeout path.

Top module: `fsq_top`

## Requirements
- R1: After synchronous reset:
  - `busy`, `done`, `id_ok`, `id_fail` and all five error flags are 0.
  - `lock_bits` equals 4'b0001.
  - Every array word holds 16'hFFFF.
  - `rd_data` reads 0.
- R2: The key is written one byte per `id_we` cycle, first byte = key bits [7:0], seventh byte = bits [55:48]. On the cycle after the seventh byte:
  - if all seven matched: `id_ok`=1 and `id_fail`=0;
  - otherwise: `id_ok`=0 and `id_fail`=1.
  The first byte of a new sequence clears both flags on the following cycle.
- R3: While `id_ok`=0:
  - `rd_data` is 0;
  - `lock_we` has no effect;
  - a command leaves the array untouched and yields `err_acc`=1 with a `done` pulse on the next cycle.
- R4: Program (`cmd_op`=2'b01) of an allowed word:
  - `busy` rises on the cycle after the command;
  - the word ends equal to `cmd_data`;
  - `busy` falls with `done` high exactly P*(L+1) cycles after the command edge. Here L = `pulse_len` (0 taken as 1) and P = number of bits to clear (at least 1).
- R5: A program whose data has a 1 where the stored word has a 0 is refused. The result is `err_prog`=1 and a `done` pulse, with no change to the word and no `busy`.
- R6: If a program needs more than 8 pulses:
  - `done` and `err_tmo`=1 come 8*(L+1) cycles after the command;
  - the word has had its 8 lowest-numbered to-be-cleared bits cleared.
- R7: Erase (`cmd_op`=2'b10) works on the block given by address bits [4:3]. All 8 of its words become 16'hFFFF, and `done` arrives L+8 cycles after the command.
- R8: A program or erase whose block has its `lock_bits` bit set is refused with `err_lock`=1 and a `done` pulse, leaving the array unchanged. `lock_we` loads `lock_mask` only while `id_ok`=1 and the sequencer is idle.
- R9: A command written while `busy`=1 is ignored: the running operation finishes unchanged, and `err_cmd` is set on the next cycle.
- R10: A command written while idle clears all five error flags, then sets exactly one according to this priority:
  1. `err_acc` (key not matched);
  2. `err_cmd` (op 2'b00 or 2'b11);
  3. `err_lock`;
  4. `err_prog`.
  An accepted command sets none of them.
- R11: `done` is high for one cycle per command outcome and is low on the cycle `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_we | input | 1 | Key byte write strobe |
| id_byte | input | 8 | Key byte |
| lock_we | input | 1 | Lock register write strobe |
| lock_mask | input | NBLK | New lock bits, one per block |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 2 | 01 program, 10 erase, others invalid |
| cmd_addr | input | AW | Word address |
| cmd_data | input | 16 | Program data |
| pulse_len | input | 8 | Cycles per pulse (0 means 1) |
| rd_addr | input | AW | Read word address |
| rd_data | output | 16 | Read data, 0 while key not matched |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| id_ok | output | 1 | Key matched |
| id_fail | output | 1 | Last key sequence mismatched |
| err_tmo | output | 1 | Program pulse budget exhausted |
| err_lock | output | 1 | Target block locked |
| err_prog | output | 1 | Program would need to set a bit |
| err_cmd | output | 1 | Invalid op or command while busy |
| err_acc | output | 1 | Command without key match |
| lock_bits | output | NBLK | Current lock bits |

## Verification
The bench targets these corners, and what a faulty design would show:
- **Key sequences.** A single wrong byte in the middle of a key sequence must end in `id_fail`; a design that compared only the last byte would report a match instead.
- **Pulse budget.** Programs needing 4, 8 and 16 bit clears, and one with nothing to clear, probe the exact completion cycle and the budget edge. A design that checked the budget before the verify would time out on an exact 8-bit clear. A design that miscounted would move `done` by a cycle.
- **Collisions and refusals.** Commands issued during a busy run, to locked blocks, and with invalid op codes must leave the array untouched. A leaking lock or a restarting sequencer would show up as a changed word or a moved `done`.
- **Lock writes without the key.** These must leave `lock_bits` unchanged; a missing gate would let the boot block be unlocked.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSV   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PPULSE,
        S_PVERIFY,
        S_EPULSE,
        S_EWALK
    } seq_state_e;

    typedef struct packed {
        logic tmo;
        logic lock;
        logic prog;
        logic cmd;
        logic acc;
    } err_t;

    // isolate the lowest set bit of a word
    function automatic word_t low_one(word_t x);
        return x & (~x + word_t'(1));
    endfunction

    // a zero pulse length is treated as one cycle
    function automatic logic [7:0] eff_len(logic [7:0] l);
        return (l == 8'd0) ? 8'd1 : l;
    endfunction
endpackage

// File: rtl/fsq_idgate.sv
`timescale 1ns/1ps
module fsq_idgate #(
    parameter int KEY_BYTES = 7,
    parameter logic [8*KEY_BYTES-1:0] KEY = '0,
    localparam int IW = $clog2(KEY_BYTES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       id_we,
    input  logic [7:0] id_byte,
    output logic       id_ok,
    output logic       id_fail
);
    logic [IW-1:0] idx;
    logic          bad;
    logic [7:0]    exp_b;
    logic          mism;

    always_comb begin
        exp_b = KEY[idx*8 +: 8];
        mism  = (id_byte != exp_b) | ((idx != '0) & bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            bad     <= 1'b0;
            id_ok   <= 1'b0;
            id_fail <= 1'b0;
        end else if (id_we) begin
            if (idx == IW'(KEY_BYTES-1)) begin
                idx     <= '0;
                bad     <= 1'b0;
                id_ok   <= !mism;
                id_fail <= mism;
            end else begin
                idx <= idx + 1'b1;
                bad <= mism;
                if (idx == '0) begin
                    id_ok   <= 1'b0;
                    id_fail <= 1'b0;
                end
            end
        end
    end

    assert_id_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(id_ok && id_fail));
    assert_id_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(id_ok) |-> $past(id_we));
endmodule

// File: rtl/fsq_array.sv
`timescale 1ns/1ps
module fsq_array
    import fsq_pkg::*;
#(
    parameter int NWORDS = 32,
    localparam int AW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a_addr,
    output word_t         a_data,
    input  logic [AW-1:0] b_addr,
    output word_t         b_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          wr_clear_only
);
    word_t mem [NWORDS];

    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // a program pulse may only clear bits, never set them
    assert_clear_only_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_clear_only) |-> ((wr_data & ~mem[wr_addr]) == '0));
endmodule

// File: rtl/fsq_seq.sv
`timescale 1ns/1ps
module fsq_seq
    import fsq_pkg::*;
#(
    parameter int NBLK = 4,
    parameter int WPB = 8,
    parameter int MAXP = 8,
    parameter logic [NBLK-1:0] LOCK_INIT = 1,
    localparam int NW = NBLK * WPB,
    localparam int AW = $clog2(NW),
    localparam int WB = $clog2(WPB),
    localparam int BW = AW - WB,
    localparam int PW = $clog2(MAXP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_we,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  word_t           cmd_data,
    input  logic [7:0]      pulse_len,
    input  logic            lock_we,
    input  logic [NBLK-1:0] lock_mask,
    input  logic            id_ok,
    output logic [AW-1:0]   arr_addr,
    input  word_t           arr_rdata,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output word_t           wr_data,
    output logic            wr_clear_only,
    output logic            busy,
    output logic            done,
    output err_t            err,
    output logic [NBLK-1:0] lock_bits
);
    seq_state_e    state;
    logic [AW-1:0] op_addr;
    word_t         op_data;
    logic [7:0]    op_len;
    logic [7:0]    cnt;
    logic [PW-1:0] pulses;
    logic [WB-1:0] widx;
    logic [NBLK-1:0] lock;
    word_t         need;
    logic          pulse_end;
    logic [BW-1:0] cmd_blk;
    logic [BW-1:0] op_blk;

    assign lock_bits = lock;
    assign busy      = (state != S_IDLE);
    assign arr_addr  = busy ? op_addr : cmd_addr;
    assign cmd_blk   = cmd_addr[AW-1:WB];
    assign op_blk    = op_addr[AW-1:WB];
    assign need      = arr_rdata & ~op_data;
    assign pulse_end = (cnt == op_len - 8'd1);

    always_comb begin
        wr_en         = 1'b0;
        wr_addr       = op_addr;
        wr_data       = arr_rdata & ~low_one(need);
        wr_clear_only = 1'b1;
        if (state == S_PPULSE && pulse_end) wr_en = 1'b1;
        if (state == S_EWALK) begin
            wr_en         = 1'b1;
            wr_addr       = {op_blk, widx};
            wr_data       = '1;
            wr_clear_only = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_addr <= '0;
            op_data <= '0;
            op_len  <= 8'd1;
            cnt     <= '0;
            pulses  <= '0;
            widx    <= '0;
            done    <= 1'b0;
            err     <= '0;
            lock    <= LOCK_INIT;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (lock_we && id_ok) lock <= lock_mask;
                    if (cmd_we) begin
                        err <= '0;
                        if (!id_ok) begin
                            err.acc <= 1'b1;
                            done    <= 1'b1;
                        end else if (cmd_op != OP_PROG && cmd_op != OP_ERASE) begin
                            err.cmd <= 1'b1;
                            done    <= 1'b1;
                        end else if (lock[cmd_blk]) begin
                            err.lock <= 1'b1;
                            done     <= 1'b1;
                        end else if (cmd_op == OP_PROG && |(cmd_data & ~arr_rdata)) begin
                            err.prog <= 1'b1;
                            done     <= 1'b1;
                        end else begin
                            op_addr <= cmd_addr;
                            op_data <= cmd_data;
                            op_len  <= eff_len(pulse_len);
                            cnt     <= '0;
                            pulses  <= '0;
                            widx    <= '0;
                            state   <= (cmd_op == OP_PROG) ? S_PPULSE : S_EPULSE;
                        end
                    end
                end
                S_PPULSE: begin
                    if (pulse_end) begin
                        pulses <= pulses + 1'b1;
                        state  <= S_PVERIFY;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                S_PVERIFY: begin
                    if (arr_rdata == op_data) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else if (pulses == PW'(MAXP)) begin
                        err.tmo <= 1'b1;
                        state   <= S_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cnt   <= '0;
                        state <= S_PPULSE;
                    end
                end
                S_EPULSE: begin
                    if (pulse_end) state <= S_EWALK;
                    else           cnt   <= cnt + 8'd1;
                end
                S_EWALK: begin
                    if (widx == WB'(WPB-1)) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
            if (busy && cmd_we) err.cmd <= 1'b1;
        end
    end

    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(id_ok));
    assert_lock_guard_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !lock[wr_addr[AW-1:WB]]);
    assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (rst)
        pulses <= PW'(MAXP));
    assert_end_done_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    assert_accept_clean_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (err == '0));
    assert_done_low_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !done);
endmodule

// File: rtl/fsq_top.sv
`timescale 1ns/1ps
module fsq_top
    import fsq_pkg::*;
#(
    parameter int NBLK = 4,
    parameter int WPB = 8,
    parameter int MAXP = 8,
    parameter logic [NBLK-1:0] LOCK_INIT = 1,
    parameter logic [55:0] KEY = 56'h5AC319E7428BD6,
    localparam int AW = $clog2(NBLK * WPB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            id_we,
    input  logic [7:0]      id_byte,
    input  logic            lock_we,
    input  logic [NBLK-1:0] lock_mask,
    input  logic            cmd_we,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [15:0]     cmd_data,
    input  logic [7:0]      pulse_len,
    input  logic [AW-1:0]   rd_addr,
    output logic [15:0]     rd_data,
    output logic            busy,
    output logic            done,
    output logic            id_ok,
    output logic            id_fail,
    output logic            err_tmo,
    output logic            err_lock,
    output logic            err_prog,
    output logic            err_cmd,
    output logic            err_acc,
    output logic [NBLK-1:0] lock_bits
);
    logic [AW-1:0] arr_addr;
    word_t         arr_rdata;
    word_t         b_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    word_t         wr_data;
    logic          wr_clear_only;
    err_t          err;

    fsq_idgate #(.KEY_BYTES(7), .KEY(KEY)) u_idgate (
        .clk(clk), .rst(rst), .id_we(id_we), .id_byte(id_byte),
        .id_ok(id_ok), .id_fail(id_fail)
    );

    fsq_array #(.NWORDS(NBLK * WPB)) u_array (
        .clk(clk), .rst(rst),
        .a_addr(arr_addr), .a_data(arr_rdata),
        .b_addr(rd_addr), .b_data(b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_clear_only(wr_clear_only)
    );

    fsq_seq #(.NBLK(NBLK), .WPB(WPB), .MAXP(MAXP), .LOCK_INIT(LOCK_INIT)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .pulse_len(pulse_len), .lock_we(lock_we), .lock_mask(lock_mask), .id_ok(id_ok),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_clear_only(wr_clear_only),
        .busy(busy), .done(done), .err(err), .lock_bits(lock_bits)
    );

    assign rd_data  = id_ok ? b_data : 16'h0000;
    assign err_tmo  = err.tmo;
    assign err_lock = err.lock;
    assign err_prog = err.prog;
    assign err_cmd  = err.cmd;
    assign err_acc  = err.acc;
endmodule

// File: tb/fsq_top_bench.sv
`timescale 1ns/1ps
module fsq_top_bench;
    localparam logic [55:0] KEYV = 56'h5AC319E7428BD6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        id_we = 1'b0;
    logic [7:0]  id_byte = '0;
    logic        lock_we = 1'b0;
    logic [3:0]  lock_mask = '0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  pulse_len = 8'd1;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy, done, id_ok, id_fail;
    logic        err_tmo, err_lock, err_prog, err_cmd, err_acc;
    logic [3:0]  lock_bits;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fsq_top u_fsq_top (
        .clk(clk), .rst(rst), .id_we(id_we), .id_byte(id_byte),
        .lock_we(lock_we), .lock_mask(lock_mask),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .pulse_len(pulse_len), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .id_ok(id_ok), .id_fail(id_fail),
        .err_tmo(err_tmo), .err_lock(err_lock), .err_prog(err_prog),
        .err_cmd(err_cmd), .err_acc(err_acc), .lock_bits(lock_bits)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_mem [32];
    logic [3:0]  m_lock;
    bit m_busy, m_done, m_ok, m_fail, m_bad;
    bit m_tmo, m_lerr, m_perr, m_cerr, m_aerr;
    int m_idx, rem;
    bit p_erase, p_tmo;
    int p_addr;
    logic [15:0] p_final;
    bit old_ok, old_busy;

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_cmd();
        logic [15:0] need, lb;
        int k, len, blk;
        m_tmo = 0; m_lerr = 0; m_perr = 0; m_cerr = 0; m_aerr = 0;
        blk = int'(cmd_addr) / 8;
        len = (pulse_len == 0) ? 1 : int'(pulse_len);
        if (!old_ok) begin m_aerr = 1; m_done = 1; end
        else if (cmd_op != 2'b01 && cmd_op != 2'b10) begin m_cerr = 1; m_done = 1; end
        else if (m_lock[blk]) begin m_lerr = 1; m_done = 1; end
        else if (cmd_op == 2'b01 && ((cmd_data & ~m_mem[cmd_addr]) != 0)) begin
            m_perr = 1; m_done = 1;
        end else if (cmd_op == 2'b10) begin
            m_busy = 1; p_erase = 1; p_tmo = 0; p_addr = blk * 8; rem = len + 8;
        end else begin
            m_busy = 1; p_erase = 0; p_addr = int'(cmd_addr);
            need = m_mem[cmd_addr] & ~cmd_data;
            k = $countones(need);
            if (k > 8) begin
                p_tmo = 1; p_final = m_mem[cmd_addr];
                for (int j = 0; j < 8; j++) begin
                    lb = need & (~need + 16'd1);
                    p_final = p_final & ~lb;
                    need = need & ~lb;
                end
                rem = 8 * (len + 1);
            end else begin
                p_tmo = 0; p_final = cmd_data;
                rem = ((k == 0) ? 1 : k) * (len + 1);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) m_mem[i] = 16'hFFFF;
            m_lock = 4'b0001; m_busy = 0; m_done = 0; m_ok = 0; m_fail = 0; m_bad = 0;
            m_tmo = 0; m_lerr = 0; m_perr = 0; m_cerr = 0; m_aerr = 0; m_idx = 0; rem = 0;
        end else begin
            old_ok = m_ok; old_busy = m_busy;
            m_done = 0;
            if (old_busy) begin
                if (cmd_we) m_cerr = 1;
                rem--;
                if (rem == 0) begin
                    m_busy = 0; m_done = 1;
                    if (p_erase) begin
                        for (int i = 0; i < 8; i++) m_mem[p_addr + i] = 16'hFFFF;
                    end else begin
                        m_mem[p_addr] = p_final;
                        if (p_tmo) m_tmo = 1;
                    end
                end
            end else if (cmd_we) begin
                model_cmd();
            end
            if (lock_we && old_ok && !old_busy) m_lock = lock_mask;
            if (id_we) begin
                if (m_idx == 0) begin m_ok = 0; m_fail = 0; m_bad = 0; end
                if (id_byte != KEYV[m_idx*8 +: 8]) m_bad = 1;
                if (m_idx == 6) begin m_ok = !m_bad; m_fail = m_bad; m_idx = 0; end
                else m_idx++;
            end
        end
        #3;
        if (!rst && !finished) begin
            chk("R4 busy", busy, m_busy);
            chk("R11 done", done, m_done);
            chk("R2 id_ok", id_ok, m_ok);
            chk("R2 id_fail", id_fail, m_fail);
            chk("R6 err_tmo", err_tmo, m_tmo);
            chk("R8 err_lock", err_lock, m_lerr);
            chk("R5 err_prog", err_prog, m_perr);
            chk("R9 R10 err_cmd", err_cmd, m_cerr);
            chk("R3 err_acc", err_acc, m_aerr);
            chk("R8 lock_bits", lock_bits, m_lock);
            if (!m_busy) chk("R4 R7 rd_data", rd_data, m_ok ? m_mem[rd_addr] : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] op, input int addr, input logic [15:0] d, input int len);
        @(negedge clk);
        cmd_op = op; cmd_addr = addr[4:0]; cmd_data = d; pulse_len = len[7:0]; cmd_we = 1;
        rd_addr = addr[4:0];
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_key(input logic [55:0] k);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            id_byte = k[i*8 +: 8]; id_we = 1;
        end
        @(negedge clk);
        id_we = 0;
    endtask

    task automatic write_lock(input logic [3:0] m);
        @(negedge clk); lock_mask = m; lock_we = 1;
        @(negedge clk); lock_we = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 busy", busy, 0);
        chk("R1 flags", {done, id_ok, id_fail, err_tmo, err_lock, err_prog, err_cmd, err_acc}, 0);
        chk("R1 lock_bits", lock_bits, 4'b0001);
        chk("R1 rd_data gated", rd_data, 0);

        // R3: command and lock write before key match
        issue(2'b01, 9, 16'h0000, 2);
        settle();
        write_lock(4'b0000);
        settle();
        chk("R3 lock write ignored", lock_bits, 4'b0001);

        // R2: wrong key then correct key
        send_key(KEYV ^ 56'h00000000100000);
        settle();
        chk("R2 mismatch fail", id_fail, 1);
        send_key(KEYV);
        settle();
        chk("R2 match ok", id_ok, 1);
        rd_addr = 5'd9;
        @(negedge clk);
        chk("R1 erased word", rd_data, 16'hFFFF);

        // R4 program 4 bits, R9 collision during busy
        issue(2'b01, 9, 16'hFFF0, 3);
        repeat (2) @(negedge clk);
        issue(2'b10, 9, 16'h0000, 1);
        settle();
        chk("R4 programmed", rd_data, 16'hFFF0);
        chk("R9 collision flagged", err_cmd, 1);

        // R5 illegal bit set
        issue(2'b01, 9, 16'hFF0F, 1);
        settle();
        chk("R5 word unchanged", rd_data, 16'hFFF0);

        // R6 timeout: 16 bits to clear
        issue(2'b01, 10, 16'h0000, 2);
        settle();
        chk("R6 partial word", rd_data, 16'hFF00);
        chk("R6 tmo", err_tmo, 1);

        // R4 exactly 8 bits, and a no-op program with pulse_len 0
        issue(2'b01, 11, 16'h00FF, 1);
        settle();
        chk("R4 eight pulses", rd_data, 16'h00FF);
        issue(2'b01, 11, 16'h00FF, 0);
        settle();

        // R8 locked boot block
        issue(2'b01, 2, 16'h1234, 1);
        settle();
        chk("R8 locked word", rd_data, 16'hFFFF);
        issue(2'b10, 3, 16'h0000, 1);
        settle();

        // R10 invalid op codes
        issue(2'b11, 12, 16'h0000, 1);
        settle();
        issue(2'b00, 12, 16'h0000, 1);
        settle();

        // R7 erase block 1
        write_lock(4'b0100);
        settle();
        issue(2'b10, 13, 16'h0000, 4);
        settle();
        for (int a = 8; a < 16; a++) begin
            rd_addr = a[4:0];
            @(negedge clk);
            chk("R7 erased", rd_data, 16'hFFFF);
        end
        issue(2'b01, 20, 16'h0000, 1);
        settle();

        // R2 re-key with a bad middle byte drops access
        send_key(KEYV ^ 56'h00000000FF0000);
        settle();
        chk("R2 access dropped", id_ok, 0);
        chk("R3 read gated", rd_data, 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule